// File: doc/BRIEF.md
# Serial Control Write with Acquisition Delay

This block receives control words on a converter's serial port and loads them into a control register. Each word arrives one bit at a time on a data line. The bits are sampled on the falling edges of a serial clock while an active-low frame strobe is held low. When the strobe returns high after exactly the expected number of bits, the word is committed.

Every write frame also starts an acquisition-delay pulse. This pulse gives the track/hold time to settle after a channel change. The pulse goes active as soon as the frame strobe falls. Its countdown starts on the sixth serial-clock fall of the frame, and it lasts for a programmable number of system clocks. That count stands in for an external timing capacitor. The pulse cannot end before the frame has closed.

A conversion requested in software, through a bit of the committed word, is held until the pulse expires and is then issued as a single-cycle strobe. A hardware start input goes straight to the strobe and never waits for the pulse.

Top module: `ctl_write_acq`

## Requirements
- R1: During and immediately after reset, `ctrl_word` is 0, `pulse_active` is 0 and `conv_start` is 0.
- R2: While `tfs_n` is low, `sdin` is sampled on each falling edge of `sclk`, MSB first. When the clock edge that first samples `tfs_n` high follows exactly WORD_W (default 8) falls, `ctrl_word` takes the shifted word at that edge.
- R3: A frame with fewer or more than WORD_W falls leaves `ctrl_word` unchanged.
- R4: `pulse_active` becomes 1 at the clock edge that first samples `tfs_n` low.
- R5: Let F be the edge that detects the sixth `sclk` fall of the frame, N the delay count, and E the edge that first samples `tfs_n` high. `pulse_active` falls at edge max(F+N+1, E+1), so a count of 0 ends the pulse one cycle after the frame closes.
- R6: If bit WORD_W-1 (bit 7 by default) of a committed word is 1, `conv_start` is high for exactly one cycle, at the same edge where `pulse_active` falls. Otherwise no software strobe occurs.
- R7: `conv_start` is high in the cycle after `hw_start` is sampled high, whatever the state of the pulse, and `pulse_active` is not affected.
- R8: A frame that starts while the pulse is active restarts the pulse from that frame. A software start that is already pending is kept and issued when the restarted pulse expires.
- R9: A frame with fewer than six `sclk` falls commits nothing and ends the pulse at edge E+1.
- R10: `acq_count` is sampled at edge F. Later changes do not alter the running delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial clock, oversampled by clk |
| sdin | input | 1 | Serial data in, MSB first |
| tfs_n | input | 1 | Active-low write frame strobe |
| hw_start | input | 1 | Hardware conversion start request |
| acq_count | input | CNT_W (16) | Delay length in system clocks |
| ctrl_word | output | WORD_W (8) | Committed control register |
| pulse_active | output | 1 | Acquisition-delay pulse in progress |
| conv_start | output | 1 | One-cycle conversion start strobe |

## Verification
The hardest case to reach is a restart. A second frame has to begin after a software start has been committed but before its delay has run out, and the check is that exactly one strobe appears, timed to the second frame. The stimulus reaches this case by writing a start request with a long count and opening a new frame a few cycles after the first one closes. The bench also changes `acq_count` right after the sixth fall of every frame, so each vector shows that the latched count governs the delay. Short frames and over-long frames show that a frame can end the pulse without committing anything.

// File: rtl/cwa_pkg.sv
package cwa_pkg;

  typedef enum logic [1:0] {
    TMR_IDLE  = 2'd0,
    TMR_ARMED = 2'd1,
    TMR_COUNT = 2'd2
  } tmr_state_t;

  // saturating increment of a bit counter held as an int
  function automatic int unsigned sat_step(int unsigned cur, int unsigned top);
    return (cur >= top) ? top : cur + 1;
  endfunction

  // edge index at which a pulse ends, given arm edge, count and close edge
  function automatic int unsigned pulse_end_edge(int unsigned arm_edge,
                                                 int unsigned count,
                                                 int unsigned close_edge);
    int unsigned a;
    int unsigned b;
    a = arm_edge + count + 1;
    b = close_edge + 1;
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cwa_edge.sv
module cwa_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic tfs_n,
  output logic sclk_fall,
  output logic frame_start,
  output logic frame_end,
  output logic frame_open
);
  logic sclk_q;
  logic tfs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      tfs_q  <= 1'b1;
    end else begin
      sclk_q <= sclk;
      tfs_q  <= tfs_n;
    end
  end

  assign sclk_fall   = sclk_q & ~sclk;
  assign frame_start = tfs_q & ~tfs_n;
  assign frame_end   = ~tfs_q & tfs_n;
  assign frame_open  = ~tfs_q;
endmodule

// File: rtl/cwa_shift.sv
module cwa_shift #(
  parameter int WORD_W   = 8,
  parameter int ARM_EDGE = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_fall,
  input  logic              in_frame,
  input  logic              sdin,
  input  logic              frame_start,
  input  logic              frame_end,
  output logic [WORD_W-1:0] ctrl_word,
  output logic              sw_req,
  output logic              arm
);
  import cwa_pkg::*;

  localparam int BC_MAX = WORD_W + 1;
  localparam int BC_W   = $clog2(BC_MAX + 1);
  localparam logic [BC_W-1:0] BC_FULL = BC_W'(WORD_W);
  localparam logic [BC_W-1:0] BC_ARM  = BC_W'(ARM_EDGE - 1);

  logic [WORD_W-1:0] shreg;
  logic [BC_W-1:0]   bitcnt;
  logic              take_bit;
  logic              commit;

  assign take_bit = sclk_fall & in_frame & ~frame_start;
  assign arm      = take_bit & (bitcnt == BC_ARM);
  assign commit   = frame_end & (bitcnt == BC_FULL);
  assign sw_req   = commit & shreg[WORD_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg  <= '0;
      bitcnt <= '0;
    end else if (frame_start) begin
      bitcnt <= '0;
    end else if (take_bit) begin
      shreg  <= {shreg[WORD_W-2:0], sdin};
      bitcnt <= BC_W'(sat_step(int'(bitcnt), BC_MAX));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      ctrl_word <= '0;
    else if (commit) ctrl_word <= shreg;
  end
endmodule

// File: rtl/cwa_timer.sv
module cwa_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             frame_end,
  input  logic             frame_open,
  input  logic             arm,
  input  logic [CNT_W-1:0] acq_count,
  input  logic             sw_req,
  input  logic             hw_start,
  output logic             pulse_active,
  output logic             expire,
  output logic             conv_start
);
  import cwa_pkg::*;

  tmr_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic             sw_pending;
  logic             cnt_zero;

  assign cnt_zero     = (cnt == '0);
  assign pulse_active = (state != TMR_IDLE);
  assign expire       = (state == TMR_COUNT) & cnt_zero & ~frame_open & ~frame_start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= TMR_IDLE;
      cnt   <= '0;
    end else if (frame_start) begin
      state <= TMR_ARMED;
      cnt   <= '0;
    end else begin
      unique case (state)
        TMR_ARMED: begin
          if (arm) begin
            state <= TMR_COUNT;
            cnt   <= acq_count;
          end else if (frame_end) begin
            state <= TMR_COUNT;
            cnt   <= '0;
          end
        end
        TMR_COUNT: begin
          if (!cnt_zero)   cnt   <= cnt - 1'b1;
          else if (expire) state <= TMR_IDLE;
        end
        default: state <= TMR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_pending <= 1'b0;
      conv_start <= 1'b0;
    end else begin
      if (sw_req)      sw_pending <= 1'b1;
      else if (expire) sw_pending <= 1'b0;
      conv_start <= hw_start | (expire & sw_pending);
    end
  end
endmodule

// File: rtl/ctl_write_acq.sv
module ctl_write_acq #(
  parameter int WORD_W   = 8,
  parameter int CNT_W    = 16,
  parameter int ARM_EDGE = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sdin,
  input  logic              tfs_n,
  input  logic              hw_start,
  input  logic [CNT_W-1:0]  acq_count,
  output logic [WORD_W-1:0] ctrl_word,
  output logic              pulse_active,
  output logic              conv_start
);
  logic sclk_fall;
  logic frame_start;
  logic frame_end;
  logic frame_open;
  logic arm;
  logic sw_req;
  logic expire;

  cwa_edge u_edge (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclk        (sclk),
    .tfs_n       (tfs_n),
    .sclk_fall   (sclk_fall),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .frame_open  (frame_open)
  );

  cwa_shift #(.WORD_W(WORD_W), .ARM_EDGE(ARM_EDGE)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclk_fall   (sclk_fall),
    .in_frame    (~tfs_n),
    .sdin        (sdin),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .ctrl_word   (ctrl_word),
    .sw_req      (sw_req),
    .arm         (arm)
  );

  cwa_timer #(.CNT_W(CNT_W)) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_start  (frame_start),
    .frame_end    (frame_end),
    .frame_open   (frame_open),
    .arm          (arm),
    .acq_count    (acq_count),
    .sw_req       (sw_req),
    .hw_start     (hw_start),
    .pulse_active (pulse_active),
    .expire       (expire),
    .conv_start   (conv_start)
  );
endmodule

// File: rtl/cwa_check.sv
module cwa_check #(
  parameter int WORD_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hw_start,
  input logic              frame_start,
  input logic              frame_end,
  input logic              frame_open,
  input logic              pulse_active,
  input logic              conv_start,
  input logic [WORD_W-1:0] ctrl_word
);
  assert_ctrl_only_at_close_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_word) |-> $past(frame_end));

  assert_pulse_on_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> pulse_active);

  assert_pulse_ends_closed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse_active) |-> $past(!frame_open));

  assert_strobe_has_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> ($past(hw_start) || $fell(pulse_active)));

  assert_hw_passes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hw_start |=> conv_start);
endmodule

bind ctl_write_acq cwa_check #(.WORD_W(WORD_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .hw_start     (hw_start),
  .frame_start  (frame_start),
  .frame_end    (frame_end),
  .frame_open   (frame_open),
  .pulse_active (pulse_active),
  .conv_start   (conv_start),
  .ctrl_word    (ctrl_word)
);

// File: tb/sim_ctl_write_acq.sv
module sim_ctl_write_acq;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 5;
  // {word[23:16], delay count[15:0]}
  localparam logic [23:0] VEC [NVEC] = '{
    {8'hA5, 16'd3}, {8'h03, 16'd0}, {8'hC2, 16'd30}, {8'h81, 16'd10}, {8'h5A, 16'd20}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b1;
  logic        sdin = 1'b0;
  logic        tfs_n = 1'b1;
  logic        hw_start = 1'b0;
  logic [15:0] acq_count = 16'd0;
  logic [7:0]  ctrl_word;
  logic        pulse_active;
  logic        conv_start;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ctl_write_acq u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdin(sdin), .tfs_n(tfs_n),
    .hw_start(hw_start), .acq_count(acq_count), .ctrl_word(ctrl_word),
    .pulse_active(pulse_active), .conv_start(conv_start)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int end_edge(input int f6, input int n, input int e);
    if (f6 < 0) return e + 1;
    return (f6 + n + 1 > e + 1) ? f6 + n + 1 : e + 1;
  endfunction

  // drives one frame; returns edge of sixth fall (or -1) and close edge
  task automatic send_frame(input logic [7:0] word, input int nbits, input int n,
                            output int f6, output int e);
    f6 = -1;
    acq_count = 16'(n);
    tfs_n = 1'b0;
    @(negedge clk); @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdin = (i < 8) ? word[7-i] : 1'b0;
      @(negedge clk);
      sclk = 1'b0;
      if (i == 5) f6 = cyc + 1;
      @(negedge clk);
      sclk = 1'b1;
      if (i == 5) acq_count = 16'hFFFF; // R10: late change must not matter
      @(negedge clk);
    end
    tfs_n = 1'b1;
    e = cyc + 1;
  endtask

  task automatic observe(input int limit, output int fall_c, output int start_c, output int nst);
    fall_c = -1; start_c = -1; nst = 0;
    for (int k = 0; k < limit; k++) begin
      @(negedge clk);
      if (fall_c < 0 && !pulse_active) fall_c = cyc;
      if (conv_start) begin
        nst++;
        if (start_c < 0) start_c = cyc;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int f6, e, fc, sc, ns, x, f6b, eb;
    logic [7:0] w;
    repeat (3) @(negedge clk);
    chk("R1 ctrl_word in reset", int'(ctrl_word), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ctrl_word after reset", int'(ctrl_word), 0);
    chk("R1 pulse_active after reset", int'(pulse_active), 0);
    chk("R1 conv_start after reset", int'(conv_start), 0);

    // table walk: R2, R5, R6, R10
    for (int v = 0; v < NVEC; v++) begin
      w = VEC[v][23:16];
      send_frame(w, 8, int'(VEC[v][15:0]), f6, e);
      observe(80, fc, sc, ns);
      x = end_edge(f6, int'(VEC[v][15:0]), e);
      chk($sformatf("R2 vec%0d ctrl_word", v), int'(ctrl_word), int'(w));
      chk($sformatf("R5 R10 vec%0d pulse end edge", v), fc, x);
      chk($sformatf("R6 vec%0d strobe count", v), ns, w[7] ? 1 : 0);
      if (w[7]) chk($sformatf("R6 vec%0d strobe edge", v), sc, x);
    end

    // R4: pulse rises on the edge that samples tfs_n low
    tfs_n = 1'b0;
    @(negedge clk);
    chk("R4 pulse_active after frame start", int'(pulse_active), 1);
    tfs_n = 1'b1;
    observe(6, fc, sc, ns);
    chk("R9 empty frame no strobe", ns, 0);

    // R8: restart while a software start is pending
    send_frame(8'h80, 8, 40, f6, e);
    observe(5, fc, sc, ns);
    chk("R8 pulse still active before restart", int'(pulse_active), 1);
    chk("R8 no early strobe", ns, 0);
    send_frame(8'h01, 8, 2, f6b, eb);
    observe(80, fc, sc, ns);
    chk("R8 restarted pulse end edge", fc, end_edge(f6b, 2, eb));
    chk("R8 pending strobe issued once", ns, 1);
    chk("R8 pending strobe edge", sc, end_edge(f6b, 2, eb));
    chk("R8 ctrl_word from second frame", int'(ctrl_word), 8'h01);

    // R7: hardware start during an active pulse
    send_frame(8'h02, 8, 40, f6, e);
    hw_start = 1'b1;
    @(negedge clk);
    hw_start = 1'b0;
    chk("R7 conv_start after hw_start", int'(conv_start), 1);
    chk("R7 pulse unaffected", int'(pulse_active), 1);
    @(negedge clk);
    chk("R7 strobe is one cycle", int'(conv_start), 0);
    observe(80, fc, sc, ns);
    chk("R7 pulse end unchanged", fc, end_edge(f6, 40, e));
    chk("R6 no software strobe without start bit", ns, 0);

    // R9: short frame of 5 bits
    send_frame(8'hFF, 5, 7, f6, e);
    observe(20, fc, sc, ns);
    chk("R9 short frame ctrl unchanged", int'(ctrl_word), 8'h02);
    chk("R9 short frame pulse end", fc, e + 1);
    chk("R9 short frame no strobe", ns, 0);

    // R3: over-long frame of 9 bits with start bit set in first 8
    send_frame(8'hF0, 9, 0, f6, e);
    observe(20, fc, sc, ns);
    chk("R3 long frame ctrl unchanged", int'(ctrl_word), 8'h02);
    chk("R3 long frame no strobe", ns, 0);
    chk("R5 long frame pulse end", fc, end_edge(f6, 0, e));

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule